// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a small byte-wide serial EEPROM that sits on a two-wire bus as a slave. It samples the bus clock and data lines with the system clock and detects start and stop conditions. It checks the first byte of each transfer against a fixed device type code and a set of strapped pins. It then loads a word address, returns data on reads, and gathers the bytes of a write in a one-page buffer. On the stop that ends a write, a timed commit phase begins. When that phase ends, the buffered bytes go into the array unless write protect was high at the stop.

The array is an on-chip register memory, organised as blocks of 256 bytes. `MEM_KBIT` sets the density to 2, 4, 8 or 16 kbit. Whatever the density, three bits of the address byte follow the type code. Some of those bits are compared with the strap pins. The others select a block of the array. The data line output is a pull-low enable, to be combined with an external pull-up.

Top module: `i2c_eeprom`

## Requirements
- R1: A start condition (SDA falls while SCL is high) begins a new transfer from any state. A stop condition (SDA rises while SCL is high) returns the slave to idle with SDA released. After the slave declines an address, it stays silent until the next start.
- R2: The address byte is sent MSB first and sampled on SCL rising edges. It matches when bits [7:4] equal 1010 and every non-block bit among bits [3:1] equals its strap pin (bit 3 to strap[2], bit 2 to strap[1], bit 1 to strap[0]). The block bits are the lowest log2(MEM_KBIT/2) of bits [3:1]; at the default 8 kbit these are bits [2:1]. On a match the slave pulls SDA low for the ninth clock. On a mismatch it never pulls SDA.
- R3: Bit 0 of the address byte selects the direction: 1 reads from the slave, 0 writes to it.
- R4: In a write, the byte after the address loads the low 8 bits of the word address. The block bits of the address byte supply the word address bits above bit 7, for reads and for writes.
- R5: Each write data byte is acknowledged and stored at the current word address. Only the low 4 bits of that address then increment, wrapping within a 16-byte page. More than 16 bytes overwrite the earliest ones in the same page.
- R6: A read drives 8 bits MSB first, changing SDA only while SCL is low. After each byte the full word address increments, across block boundaries. Reading continues while the master acknowledges, and a master NACK ends it.
- R7: When write protect is high at the stop that ends a write, the address and data bytes are still acknowledged, but the array keeps its previous contents.
- R8: A stop after at least one write data byte starts a commit phase of WRITE_CYCLES clock cycles. During that phase the slave declines its address; after it, the address is acknowledged again. A transfer that carries no data bytes starts no commit phase.
- R9: A read that is not preceded by a word-address write continues from the word address left by the previous access, with its block bits taken from the new address byte.
- R10: The SDA pull-low enable changes only while the synchronised SCL is low.
- R11: After reset SDA is released, the slave is idle and every array byte reads FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| strap_i | input | 3 | Strapped address pins {bit3, bit2, bit1 of the address byte} |
| wp_i | input | 1 | Write protect for the whole array, high locks |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The commit phase that follows a write can overlap the next transfer's address recognition. The bench provokes this by sending a start and the address byte at once after a stop that ends a page write, and it expects the ninth-clock acknowledge to be absent. It repeats the attempt after the commit phase has run out, and then expects the acknowledge. A second overlap is the page-offset wrap landing on the same page slot as an earlier byte of the same transfer. The bench provokes it by writing 18 bytes in one transfer and judges it by reading back the overwritten slots and the slot that follows them.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam logic [3:0] TYPE_CODE = 4'b1010;
  localparam int AW_MAX = 11;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_WADDR, S_WDATA, S_ACK, S_RDATA, S_RACK
  } ee_state_e;

  // Address byte match: type code plus every strap bit that is not a block bit
  function automatic logic dev_match(logic [7:0] dev, logic [2:0] strap, int blk_bits);
    logic ok;
    ok = (dev[7:4] == TYPE_CODE);
    for (int i = 0; i < 3; i++)
      if (i >= blk_bits && dev[i+1] != strap[i]) ok = 1'b0;
    return ok;
  endfunction

  // Replace the word-address bits above bit 7 with the block bits of the address byte
  function automatic logic [AW_MAX-1:0] with_block(logic [AW_MAX-1:0] a, logic [7:0] dev, int blk_bits);
    logic [AW_MAX-1:0] r;
    r = a;
    for (int i = 0; i < 3; i++)
      if (i < blk_bits) r[8+i] = dev[1+i];
    return r;
  endfunction

  // Increment only the low page_bits, wrapping inside the page
  function automatic logic [AW_MAX-1:0] page_step(logic [AW_MAX-1:0] a, int page_bits);
    logic [AW_MAX-1:0] inc;
    logic [AW_MAX-1:0] r;
    inc = a + 1'b1;
    r = a;
    for (int i = 0; i < AW_MAX; i++)
      if (i < page_bits) r[i] = inc[i];
    return r;
  endfunction
endpackage

// File: rtl/ee_bus_monitor.sv
module ee_bus_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_sh[SYNC_STAGES-1];
      sda_prev <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_lvl_o  = scl_sh[SYNC_STAGES-1];
  assign sda_lvl_o  = sda_sh[SYNC_STAGES-1];
  assign scl_rise_o = scl_lvl_o & ~scl_prev;
  assign scl_fall_o = ~scl_lvl_o & scl_prev;
  assign start_o    = scl_lvl_o & scl_prev & sda_prev & ~sda_lvl_o;
  assign stop_o     = scl_lvl_o & scl_prev & ~sda_prev & sda_lvl_o;
endmodule

// File: rtl/ee_page_buffer.sv
module ee_page_buffer #(
  parameter int PAGE_BYTES = 16,
  parameter int BASE_W     = 6,
  localparam int PAGE_BITS = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [BASE_W-1:0]       base_i,
  input  logic                    clear_i,
  input  logic                    wr_i,
  input  logic [PAGE_BITS-1:0]    wr_idx_i,
  input  logic [7:0]              wr_data_i,
  output logic [BASE_W-1:0]       base_o,
  output logic [PAGE_BYTES-1:0]   mask_o,
  output logic [PAGE_BYTES*8-1:0] data_o,
  output logic                    any_o
);
  logic [BASE_W-1:0]       base_q;
  logic [PAGE_BYTES-1:0]   mask_q;
  logic [PAGE_BYTES*8-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      data_q <= '0;
    end else begin
      if (load_i || clear_i) mask_q <= '0;
      if (load_i) base_q <= base_i;
      if (wr_i) begin
        data_q[wr_idx_i*8 +: 8] <= wr_data_i;
        mask_q[wr_idx_i]        <= 1'b1;
      end
    end
  end

  assign base_o = base_q;
  assign mask_o = mask_q;
  assign data_o = data_q;
  assign any_o  = |mask_q;

  // R5: a load never coincides with a byte store
  a_r5_load_wr_excl: assert property (@(posedge clk) disable iff (!rst_n) !(load_i && wr_i));
endmodule

// File: rtl/ee_write_timer.sv
module ee_write_timer #(
  parameter int WRITE_CYCLES = 2000,
  localparam int CW = $clog2(WRITE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic wp_i,
  output logic busy_o,
  output logic done_o,
  output logic commit_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          wp_lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      wp_lat_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q   <= 1'b1;
        cnt_q    <= '0;
        wp_lat_q <= wp_i;
      end
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = busy_q && (cnt_q == CW'(WRITE_CYCLES - 1));
  assign commit_o = done_o && !wp_lat_q;

  // R8: a started commit phase shows busy on the next cycle
  a_r8_busy_starts: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_q) |=> busy_o);
  // R7: a commit never writes when protect was latched high
  a_r7_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n) (busy_q && wp_lat_q) |-> !commit_o);
endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16,
  localparam int PAGE_BITS = $clog2(PAGE_BYTES),
  localparam int BASE_W    = ADDR_W - PAGE_BITS,
  localparam int DEPTH     = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit_i,
  input  logic [BASE_W-1:0]       base_i,
  input  logic [PAGE_BYTES-1:0]   mask_i,
  input  logic [PAGE_BYTES*8-1:0] data_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [7:0]              rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (mask_i[i]) mem[{base_i, PAGE_BITS'(i)}] <= data_i[i*8 +: 8];
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2c_eeprom.sv
module i2c_eeprom
  import ee_pkg::*;
#(
  parameter int MEM_KBIT     = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 2000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  localparam int NUM_BLOCKS = MEM_KBIT / 2;
  localparam int BLK_BITS   = $clog2(NUM_BLOCKS);
  localparam int ADDR_W     = 8 + BLK_BITS;
  localparam int PAGE_BITS  = $clog2(PAGE_BYTES);
  localparam int BASE_W     = ADDR_W - PAGE_BITS;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

  ee_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_evt), .stop_o(stop_evt)
  );

  ee_state_e         state_q, next_q;
  logic [3:0]        bitcnt_q;
  logic [7:0]        shreg_q;
  logic [ADDR_W-1:0] addr_q;
  logic              racked_q;
  logic              pull_q;

  // internal events, named for the assertions
  logic              rx_done, dev_ok, buf_load, buf_wr, buf_any;
  logic              busy, wc_done, commit;
  logic [ADDR_W-1:0] addr_dev, addr_word, addr_page;
  logic [7:0]        mem_rdata;
  logic [BASE_W-1:0]       buf_base;
  logic [PAGE_BYTES-1:0]   buf_mask;
  logic [PAGE_BYTES*8-1:0] buf_data;

  always_comb begin
    logic [AW_MAX-1:0] t_dev, t_word, t_page;
    t_dev       = with_block(AW_MAX'(addr_q), shreg_q, BLK_BITS);
    t_word      = AW_MAX'(addr_q);
    t_word[7:0] = shreg_q;
    t_page      = page_step(AW_MAX'(addr_q), PAGE_BITS);
    addr_dev    = t_dev[ADDR_W-1:0];
    addr_word   = t_word[ADDR_W-1:0];
    addr_page   = t_page[ADDR_W-1:0];
  end

  assign rx_done  = scl_fall && (bitcnt_q == 4'd8);
  assign dev_ok   = dev_match(shreg_q, strap_i, BLK_BITS) && !busy;
  assign buf_load = (state_q == S_WADDR) && rx_done && !start_evt && !stop_evt;
  assign buf_wr   = (state_q == S_WDATA) && rx_done && !start_evt && !stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      next_q   <= S_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      addr_q   <= '0;
      racked_q <= 1'b0;
      pull_q   <= 1'b0;
    end else if (start_evt) begin
      state_q  <= S_DEV;
      bitcnt_q <= '0;
      pull_q   <= 1'b0;
    end else if (stop_evt) begin
      state_q  <= S_IDLE;
      pull_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_DEV, S_WADDR, S_WDATA: begin
          if (scl_rise && bitcnt_q != 4'd8) begin
            shreg_q  <= {shreg_q[6:0], sda_lvl};
            bitcnt_q <= bitcnt_q + 1'b1;
          end
          if (rx_done) begin
            if (state_q == S_DEV) begin
              if (dev_ok) begin
                pull_q  <= 1'b1;
                addr_q  <= addr_dev;
                next_q  <= shreg_q[0] ? S_RDATA : S_WADDR;
                state_q <= S_ACK;
              end else begin
                state_q <= S_IDLE;
              end
            end else if (state_q == S_WADDR) begin
              addr_q  <= addr_word;
              pull_q  <= 1'b1;
              next_q  <= S_WDATA;
              state_q <= S_ACK;
            end else begin
              addr_q  <= addr_page;
              pull_q  <= 1'b1;
              next_q  <= S_WDATA;
              state_q <= S_ACK;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt_q <= '0;
            state_q  <= next_q;
            if (next_q == S_RDATA) begin
              shreg_q <= mem_rdata;
              pull_q  <= ~mem_rdata[7];
            end else begin
              pull_q  <= 1'b0;
            end
          end
        end
        S_RDATA: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd7) begin
              pull_q  <= 1'b0;
              addr_q  <= addr_q + 1'b1;
              state_q <= S_RACK;
            end else begin
              bitcnt_q <= bitcnt_q + 1'b1;
              shreg_q  <= {shreg_q[6:0], 1'b0};
              pull_q   <= ~shreg_q[6];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) racked_q <= ~sda_lvl;
          if (scl_fall) begin
            if (racked_q) begin
              bitcnt_q <= '0;
              shreg_q  <= mem_rdata;
              pull_q   <= ~mem_rdata[7];
              state_q  <= S_RDATA;
            end else begin
              state_q  <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  ee_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .BASE_W(BASE_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load_i(buf_load), .base_i(addr_word[ADDR_W-1:PAGE_BITS]),
    .clear_i(wc_done),
    .wr_i(buf_wr), .wr_idx_i(addr_q[PAGE_BITS-1:0]), .wr_data_i(shreg_q),
    .base_o(buf_base), .mask_o(buf_mask), .data_o(buf_data), .any_o(buf_any)
  );

  ee_write_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start_i(stop_evt && buf_any), .wp_i(wp_i),
    .busy_o(busy), .done_o(wc_done), .commit_o(commit)
  );

  ee_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n),
    .commit_i(commit), .base_i(buf_base), .mask_i(buf_mask), .data_i(buf_data),
    .raddr_i(addr_q), .rdata_o(mem_rdata)
  );

  assign sda_pull_o = pull_q;

  // R10: the pull enable only moves while SCL is low
  a_r10_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !scl_lvl);
  // R11 / R1: an idle slave never pulls the line
  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> !pull_q);
  // R8: an address acknowledge is never given during the commit phase
  a_r8_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ACK && $past(state_q) == S_DEV) |-> !busy);
  // R5: a stored byte leaves the page number of the word address unchanged
  a_r5_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |=> $stable(addr_q[ADDR_W-1:PAGE_BITS]));
endmodule

// File: tb/i2c_eeprom_bench.sv
module i2c_eeprom_bench;
  localparam int WC = 2000;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic [2:0] strap = 3'b100;
  logic pull;
  logic sda_line;
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  assign sda_line = sda_m & ~pull;

  i2c_eeprom #(.WRITE_CYCLES(WC)) u_i2c_eeprom (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .wp_i(wp), .sda_pull_o(pull)
  );

  // {address byte, is_read, expected ack}; strap = 100
  localparam logic [9:0] VEC [8] = '{
    {8'hA8, 1'b0, 1'b1}, {8'hAB, 1'b1, 1'b1}, {8'hAE, 1'b0, 1'b1}, {8'hAF, 1'b1, 1'b1},
    {8'hA0, 1'b0, 1'b0}, {8'hA7, 1'b1, 1'b0}, {8'hB8, 1'b0, 1'b0}, {8'h28, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); b = sda_line; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic rd_byte(input bit ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(!ack);
  endtask

  function automatic logic [7:0] devb(input logic [1:0] blk, input logic rd);
    return {4'b1010, 1'b1, blk, rd};
  endfunction

  task automatic write_seq(input logic [1:0] blk, input logic [7:0] wa, input int n,
                           input logic [7:0] v0, input string tag);
    bit ack;
    bus_start();
    wr_byte(devb(blk, 1'b0), ack); chk(ack, {tag, " addr ack"}, ack, 1);
    wr_byte(wa, ack);              chk(ack, {tag, " word ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      wr_byte(v0 + 8'(k), ack);
      if (k == 0 || k == n - 1) chk(ack, {tag, " data ack"}, ack, 1);
    end
    bus_stop();
  endtask

  logic [7:0] rb [20];

  task automatic read_seq(input logic [1:0] blk, input logic [7:0] wa, input int n);
    bit ack;
    bus_start();
    wr_byte(devb(blk, 1'b0), ack);
    wr_byte(wa, ack);
    bus_start();
    wr_byte(devb(blk, 1'b1), ack);
    for (int k = 0; k < n; k++) rd_byte(k != n - 1, rb[k]);
    bus_stop();
  endtask

  task automatic wait_wc();
    repeat (WC + 100) @(negedge clk);
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk(pull == 1'b0, "R11 reset releases SDA", pull, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pull == 1'b0, "R11 idle after reset", pull, 0);

    // address-match table (R1/R2/R3)
    for (int v = 0; v < 8; v++) begin
      bus_start();
      wr_byte(VEC[v][9:2], ack);
      chk(ack == VEC[v][0], $sformatf("R2 address %0h", VEC[v][9:2]), ack, VEC[v][0]);
      if (ack && VEC[v][1]) begin
        rd_byte(1'b0, d);
        chk(d == 8'hFF, "R3/R11 read of erased array", d, 8'hFF);
      end else if (!ack) begin
        chk(pull == 1'b0, "R1 silent after mismatch", pull, 0);
      end
      bus_stop();
    end

    // page write then immediate re-address (R8), then readback (R4/R5/R6)
    write_seq(2'd0, 8'h10, 3, 8'h11, "R5 write");
    bus_start();
    wr_byte(devb(2'd0, 1'b0), ack);
    chk(!ack, "R8 no ack during commit phase", ack, 0);
    bus_stop();
    wait_wc();
    bus_start();
    wr_byte(devb(2'd0, 1'b0), ack);
    chk(ack, "R8 ack after commit phase", ack, 1);
    bus_stop();
    read_seq(2'd0, 8'h10, 3);
    chk(rb[0] == 8'h11, "R4 byte at 010", rb[0], 8'h11);
    chk(rb[1] == 8'h12, "R6 sequential 011", rb[1], 8'h12);
    chk(rb[2] == 8'h13, "R6 sequential 012", rb[2], 8'h13);

    // page wrap in block 1 (R5)
    write_seq(2'd1, 8'h1E, 4, 8'hA0, "R5 wrap write");
    wait_wc();
    read_seq(2'd1, 8'h1E, 2);
    chk(rb[0] == 8'hA0, "R5 byte 11E", rb[0], 8'hA0);
    chk(rb[1] == 8'hA1, "R5 byte 11F", rb[1], 8'hA1);
    read_seq(2'd1, 8'h10, 2);
    chk(rb[0] == 8'hA2, "R5 wrapped byte 110", rb[0], 8'hA2);
    chk(rb[1] == 8'hA3, "R5 wrapped byte 111", rb[1], 8'hA3);
    read_seq(2'd1, 8'h20, 1);
    chk(rb[0] == 8'hFF, "R5 next page untouched", rb[0], 8'hFF);

    // 18 bytes into one page: overwrite (R5), then current-address read (R9)
    write_seq(2'd2, 8'h40, 18, 8'h50, "R5 long write");
    wait_wc();
    read_seq(2'd2, 8'h40, 3);
    chk(rb[0] == 8'h60, "R5 overwrite 240", rb[0], 8'h60);
    chk(rb[1] == 8'h61, "R5 overwrite 241", rb[1], 8'h61);
    chk(rb[2] == 8'h52, "R5 kept 242", rb[2], 8'h52);
    bus_start();
    wr_byte(devb(2'd2, 1'b1), ack);
    rd_byte(1'b0, d);
    bus_stop();
    chk(d == 8'h53, "R9 current address read 243", d, 8'h53);

    // read across a block boundary (R6)
    write_seq(2'd0, 8'hFF, 1, 8'h77, "R6 write 0FF");
    wait_wc();
    write_seq(2'd1, 8'h00, 1, 8'h88, "R6 write 100");
    wait_wc();
    read_seq(2'd0, 8'hFF, 2);
    chk(rb[0] == 8'h77, "R6 byte 0FF", rb[0], 8'h77);
    chk(rb[1] == 8'h88, "R6 crosses into block 1", rb[1], 8'h88);

    // write protect (R7)
    wp = 1'b1;
    write_seq(2'd3, 8'h05, 1, 8'h99, "R7 protected write");
    wait_wc();
    wp = 1'b0;
    read_seq(2'd3, 8'h05, 1);
    chk(rb[0] == 8'hFF, "R7 protected byte unchanged", rb[0], 8'hFF);

    // transfer without data starts no commit phase (R8)
    bus_start();
    wr_byte(devb(2'd3, 1'b0), ack);
    wr_byte(8'h00, ack);
    bus_stop();
    bus_start();
    wr_byte(devb(2'd3, 1'b0), ack);
    chk(ack, "R8 no commit phase without data", ack, 1);
    bus_stop();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule